// File: doc/BRIEF.md
# Shared-Multiplier Montgomery Product Datapath

This block computes a word-serial Montgomery product T = A·B·2^(-W·M) (mod N) over M = 4·CORES words of W bits. The words are grouped into arithmetic cores. Each core owns a single W×W multiply-accumulate block and four small adder lanes. The multiply block serves its four lanes one after the other, least significant word first. Each lane adds the two low product words it receives, plus one carry bit from the lane below, and writes one word of the running result. The wide product carries pass from one multiply block to the next, so only a one-bit carry travels between lanes.

Before a product, the modulus N and the operand B are preloaded word by word into the core-local stores. N stays resident, so a later product only has to reload B. After `start`, the block runs M iterations. In each iteration it asks for one word a_i of operand A and forms the quotient word. It then sweeps the M word lanes and finishes with a top-word step, which folds the last multiply carries into the two highest result words. The M+1 result words are then read through a W-bit selector. No final subtraction is made. When the caller keeps N < 2^(W·M−2) and A, B < 2N, the result stays below 2N and can be fed straight back in.

Top module: `mont_shared_mul`

## Requirements
- R1: After reset, `busy` and `done` are low and every result word read through `rd_idx` is zero.
- R2: Let N be odd with N < 2^(W·M−2), let A, B < 2N, and let `n_inv` = −N^(−1) mod 2^W. When `done` rises, the result words 0..M (word 0 least significant) hold T with T·2^(W·M) ≡ A·B (mod N) and T < 2N. T equals the word-serial value that adds a_i·B + q_i·N and shifts right by W, once per iteration.
- R3: A `start` sampled while idle raises `busy` on the next cycle. `done` is a one-cycle pulse, seen exactly M·(M+2) cycles after the `start` edge, and `busy` is low in that same cycle.
- R4: During a product, `a_req` is high for exactly one cycle per iteration, with `a_idx` = 0, 1, …, M−1 in order. `a_word` is sampled in that cycle.
- R5: While idle, `ld_en` writes `ld_data` into word `ld_addr` (0 = least significant) of B when `ld_mod` = 0, or of N when `ld_mod` = 1. Stored words persist, so a product that reloads only B reuses the resident N.
- R6: `ld_en` is ignored while `busy` is high. Neither the running product nor any later product sees that write.
- R7: `start` is ignored while `busy` is high. The running product keeps its timing and its A fetch order.
- R8: `rd_word` returns result word `rd_idx` for `rd_idx` ≤ M, and zero for larger values.
- R9: While idle and with no `start`, the result words do not change, even when loads take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a product (ignored while busy) |
| n_inv | input | W_BITS | −N^(−1) mod 2^W, held during a product |
| a_req | output | 1 | Operand A word request strobe |
| a_idx | output | $clog2(M) | Index of the requested A word |
| a_word | input | W_BITS | Requested A word, sampled while `a_req` is high |
| ld_en | input | 1 | Preload write enable |
| ld_mod | input | 1 | Preload target: 0 = B, 1 = N |
| ld_addr | input | $clog2(M) | Preload word index |
| ld_data | input | W_BITS | Preload word |
| rd_idx | input | $clog2(M+1) | Result word select |
| rd_word | output | W_BITS | Selected result word |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle: a preload write or a fresh `start`, and a product that is still sweeping its lanes. The bench provokes the overlap during a running product. It drives a junk B word partway through the sweep and, some cycles later, a second `start`. It then judges the outcome at the ports. The result must still match the value computed from the original B. The completion time must count from the first `start`. The A fetch sequence must run 0..M−1 exactly once. A following product that does not reload B must also return the original result.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUOT  = 2'd1,
    ST_SWEEP = 2'd2,
    ST_TOP   = 2'd3
  } mmx_state_e;

endpackage

// File: rtl/mmx_ctrl.sv
module mmx_ctrl
  import mmx_pkg::*;
#(
  parameter int M = 8,
  localparam int IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          a_req,
  output logic          sweep_act,
  output logic          top_act,
  output logic          clr_t,
  output logic          done,
  output logic [IW-1:0] iter,
  output logic [IW-1:0] step
);

  mmx_state_e st;

  assign busy      = (st != ST_IDLE);
  assign a_req     = (st == ST_QUOT);
  assign sweep_act = (st == ST_SWEEP);
  assign top_act   = (st == ST_TOP);
  assign clr_t     = (st == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      iter <= '0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_QUOT;
            iter <= '0;
          end
        end
        ST_QUOT: begin
          st   <= ST_SWEEP;
          step <= '0;
        end
        ST_SWEEP: begin
          if (step == IW'(M - 1)) st <= ST_TOP;
          else step <= step + IW'(1);
        end
        ST_TOP: begin
          if (iter == IW'(M - 1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            iter <= iter + IW'(1);
            st   <= ST_QUOT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mmx_mult_blk.sv
module mmx_mult_blk #(
  parameter int W     = 16,
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES),
  localparam int DW   = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [LW-1:0] k,
  input  logic [W-1:0]  a_w,
  input  logic [W-1:0]  q_w,
  input  logic [W-1:0]  t_w,
  input  logic [W-1:0]  ca_ext,
  input  logic [W-1:0]  cq_ext,
  input  logic          wr_en,
  input  logic          wr_mod,
  input  logic [LW-1:0] wr_k,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  u_lo,
  output logic [W-1:0]  v_lo,
  output logic [W-1:0]  ca_q,
  output logic [W-1:0]  cq_q
);

  // x*y + p + r never exceeds 2W bits
  function automatic logic [DW-1:0] mac(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic [W-1:0] p, input logic [W-1:0] r);
    return DW'(x) * DW'(y) + DW'(p) + DW'(r);
  endfunction

  logic [W-1:0]  b_mem [LANES];
  logic [W-1:0]  n_mem [LANES];
  logic [W-1:0]  ca_in, cq_in;
  logic [DW-1:0] u_full, v_full;

  always_comb begin
    ca_in  = (k == '0) ? ca_ext : ca_q;
    cq_in  = (k == '0) ? cq_ext : cq_q;
    u_full = mac(a_w, b_mem[k], t_w, ca_in);
    v_full = mac(q_w, n_mem[k], '0, cq_in);
    u_lo   = u_full[W-1:0];
    v_lo   = v_full[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cq_q <= '0;
      for (int i = 0; i < LANES; i++) begin
        b_mem[i] <= '0;
        n_mem[i] <= '0;
      end
    end else begin
      if (act) begin
        ca_q <= u_full[DW-1:W];
        cq_q <= v_full[DW-1:W];
      end
      if (wr_en) begin
        if (wr_mod) n_mem[wr_k] <= wr_data;
        else        b_mem[wr_k] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/mmx_pe.sv
module mmx_pe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic [W-1:0] u,
  input  logic [W-1:0] v,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout_q
);

  function automatic logic [W:0] lane_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return (W+1)'(x) + (W+1)'(y) + (W+1)'(c);
  endfunction

  logic [W:0] s;

  assign s   = lane_add(u, v, cin);
  assign res = s[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cout_q <= 1'b0;
    else if (vld) cout_q <= s[W];
  end

endmodule

// File: rtl/mont_shared_mul.sv
module mont_shared_mul #(
  parameter int W_BITS = 16,
  parameter int CORES  = 2,
  localparam int LANES = 4,
  localparam int M     = CORES * LANES,
  localparam int IW    = $clog2(M),
  localparam int RW    = $clog2(M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W_BITS-1:0] n_inv,
  output logic              a_req,
  output logic [IW-1:0]     a_idx,
  input  logic [W_BITS-1:0] a_word,
  input  logic              ld_en,
  input  logic              ld_mod,
  input  logic [IW-1:0]     ld_addr,
  input  logic [W_BITS-1:0] ld_data,
  input  logic [RW-1:0]     rd_idx,
  output logic [W_BITS-1:0] rd_word,
  output logic              busy,
  output logic              done
);

  localparam int W  = W_BITS;
  localparam int LW = $clog2(LANES);
  localparam int CW = IW - LW;

  // quotient word: ((t0 + a*b0) mod 2^W) * n_inv mod 2^W
  function automatic logic [W-1:0] quot_word(input logic [W-1:0] t0, input logic [W-1:0] a,
                                             input logic [W-1:0] b0, input logic [W-1:0] ni);
    logic [W-1:0] s;
    s = W'(a * b0) + t0;
    return W'(s * ni);
  endfunction

  // top step: two final carries, old top word and last lane carry
  function automatic logic [W+1:0] top_sum(input logic [W-1:0] ca, input logic [W-1:0] cq,
                                           input logic [W-1:0] tm, input logic c);
    return (W+2)'(ca) + (W+2)'(cq) + (W+2)'(tm) + (W+2)'(c);
  endfunction

  logic          sweep_act, top_act, clr_t, ld_ok;
  logic [IW-1:0] step;
  logic [W-1:0]  t_mem [M+1];
  logic [W-1:0]  a_q, q_q, b0_sh;
  logic [W+1:0]  top_s;

  logic [W-1:0]  ca_q [CORES];
  logic [W-1:0]  cq_q [CORES];
  logic [W-1:0]  ca_ext [CORES];
  logic [W-1:0]  cq_ext [CORES];
  logic [W-1:0]  u_lo [CORES];
  logic [W-1:0]  v_lo [CORES];

  logic [M-1:0]  pe_vld;
  logic [M-1:0]  pe_cin;
  logic [M-1:0]  pe_cout;
  logic [W-1:0]  pe_res [M];

  // observation wires for the checker
  logic [W-1:0]       first_drop;
  logic [(M+1)*W-1:0] t_flat;

  assign ld_ok      = ld_en && !busy;
  assign first_drop = pe_res[0];
  assign top_s      = top_sum(ca_q[CORES-1], cq_q[CORES-1], t_mem[M], pe_cout[M-1]);

  mmx_ctrl #(.M(M)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .a_req     (a_req),
    .sweep_act (sweep_act),
    .top_act   (top_act),
    .clr_t     (clr_t),
    .done      (done),
    .iter      (a_idx),
    .step      (step)
  );

  for (genvar c = 0; c < CORES; c++) begin : g_core
    logic act_c, wr_c;
    assign act_c = sweep_act && (step[IW-1:LW] == CW'(c));
    assign wr_c  = ld_ok && (ld_addr[IW-1:LW] == CW'(c));

    if (c == 0) begin : g_head
      assign ca_ext[c] = '0;
      assign cq_ext[c] = '0;
    end else begin : g_chain
      assign ca_ext[c] = ca_q[c-1];
      assign cq_ext[c] = cq_q[c-1];
    end

    mmx_mult_blk #(.W(W), .LANES(LANES)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act_c),
      .k       (step[LW-1:0]),
      .a_w     (a_q),
      .q_w     (q_q),
      .t_w     (t_mem[step]),
      .ca_ext  (ca_ext[c]),
      .cq_ext  (cq_ext[c]),
      .wr_en   (wr_c),
      .wr_mod  (ld_mod),
      .wr_k    (ld_addr[LW-1:0]),
      .wr_data (ld_data),
      .u_lo    (u_lo[c]),
      .v_lo    (v_lo[c]),
      .ca_q    (ca_q[c]),
      .cq_q    (cq_q[c])
    );
  end

  for (genvar j = 0; j < M; j++) begin : g_lane
    assign pe_vld[j] = sweep_act && (step == IW'(j));
    if (j == 0) begin : g_first
      assign pe_cin[j] = 1'b0;
    end else begin : g_next
      assign pe_cin[j] = pe_cout[j-1];
    end

    mmx_pe #(.W(W)) u_pe (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (pe_vld[j]),
      .u      (u_lo[j / LANES]),
      .v      (v_lo[j / LANES]),
      .cin    (pe_cin[j]),
      .res    (pe_res[j]),
      .cout_q (pe_cout[j])
    );
  end

  for (genvar i = 0; i <= M; i++) begin : g_flat
    assign t_flat[i*W +: W] = t_mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      q_q   <= '0;
      b0_sh <= '0;
      for (int i = 0; i <= M; i++) t_mem[i] <= '0;
    end else begin
      if (ld_ok && !ld_mod && (ld_addr == '0)) b0_sh <= ld_data;
      if (a_req) begin
        a_q <= a_word;
        q_q <= quot_word(t_mem[0], a_word, b0_sh, n_inv);
      end
      if (clr_t) begin
        for (int i = 0; i <= M; i++) t_mem[i] <= '0;
      end else if (sweep_act && (step != '0)) begin
        t_mem[step - IW'(1)] <= pe_res[step];
      end else if (top_act) begin
        t_mem[M-1] <= top_s[W-1:0];
        t_mem[M]   <= W'(top_s[W+1:W]);
      end
    end
  end

  always_comb begin
    if (rd_idx <= RW'(M)) rd_word = t_mem[rd_idx];
    else                  rd_word = '0;
  end

endmodule

// File: rtl/mont_shared_mul_chk.sv
module mont_shared_mul_chk #(
  parameter int W = 16,
  parameter int M = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               a_req,
  input logic [M-1:0]       pe_vld,
  input logic [W-1:0]       first_drop,
  input logic [(M+1)*W-1:0] t_flat
);

  logic [15:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat <= '0;
    else if (start && !busy)   lat <= '0;
    else if (busy)             lat <= lat + 16'd1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat == 16'(M * (M + 2)))); // R3
  AST_AREQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) a_req |-> busy); // R4
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pe_vld)); // R2
  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pe_vld[0] |-> (first_drop == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(t_flat)); // R9

endmodule

bind mont_shared_mul mont_shared_mul_chk #(.W(W_BITS), .M(M)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .a_req      (a_req),
  .pe_vld     (pe_vld),
  .first_drop (first_drop),
  .t_flat     (t_flat)
);

// File: tb/mont_shared_mul_tb.sv
`timescale 1ns/1ps
module mont_shared_mul_tb;
  localparam int W   = 16;
  localparam int M   = 8;
  localparam int LAT = M * (M + 2);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, ld_en, ld_mod, a_req, busy, done;
  logic [W-1:0]  n_inv, a_word, ld_data, rd_word;
  logic [2:0]    a_idx, ld_addr;
  logic [3:0]    rd_idx;
  logic [127:0]  cur_a;

  int n_chk = 0;
  int n_fail = 0;

  mont_shared_mul u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_inv(n_inv), .a_req(a_req), .a_idx(a_idx),
    .a_word(a_word), .ld_en(ld_en), .ld_mod(ld_mod), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_word(rd_word), .busy(busy), .done(done)
  );

  always_comb a_word = cur_a[a_idx*W +: W];

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] inv_neg(input logic [15:0] n0);
    logic [15:0] x;
    x = 16'd1;
    for (int i = 0; i < 5; i++) x = x * (16'd2 - n0 * x);
    return -x;
  endfunction

  // whole-number restatement of the word-serial product
  function automatic logic [255:0] ref_prod(input logic [255:0] a, input logic [255:0] b,
                                            input logic [255:0] n, input logic [15:0] ni);
    logic [255:0] t, s;
    logic [15:0]  ai, qi;
    t = '0;
    for (int i = 0; i < M; i++) begin
      ai = a[i*W +: W];
      s  = t + ai * b;
      qi = s[15:0] * ni;
      t  = (s + qi * n) >> W;
    end
    return t;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic load_vec(input bit md, input logic [127:0] v);
    for (int i = 0; i < M; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_mod = md; ld_addr = 3'(i); ld_data = v[i*W +: W];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read_res(output logic [255:0] r);
    r = '0;
    for (int i = 0; i <= M; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      r[i*W +: W] = rd_word;
    end
  endtask

  task automatic run(input logic [127:0] a, input bit inject, output logic [255:0] r,
                     output int lat, output bit order_ok);
    int nreq;
    lat = 0; nreq = 0; order_ok = 1'b1;
    cur_a = a;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 2000) begin
      if (a_req) begin
        if (a_idx != 3'(nreq)) order_ok = 1'b0;
        nreq++;
      end
      if (inject && lat == 20) begin
        ld_en = 1'b1; ld_mod = 1'b0; ld_addr = 3'd0; ld_data = 16'hDEAD;
      end
      if (inject && lat == 21) ld_en = 1'b0;
      if (inject && lat == 30) start = 1'b1;
      if (inject && lat == 31) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (nreq != M) order_ok = 1'b0;
    check(!busy, "R3 busy low with done", 256'(busy), 256'(0));
    @(negedge clk);
    check(!done, "R3 done single pulse", 256'(done), 256'(0));
    read_res(r);
  endtask

  task automatic one_case(input string tag, input logic [127:0] n, input logic [127:0] a,
                          input logic [127:0] b, input bit ldn, input bit ldb, input bit inject,
                          input logic [127:0] b_model);
    logic [255:0] r, e, lhs, rhs;
    int lat;
    bit ok;
    n_inv = inv_neg(n[15:0]);
    if (ldn) load_vec(1'b1, n);
    if (ldb) load_vec(1'b0, b);
    run(a, inject, r, lat, ok);
    e   = ref_prod(256'(a), 256'(b_model), 256'(n), n_inv);
    lhs = (r << 128) % 256'(n);
    rhs = (256'(a) * 256'(b_model)) % 256'(n);
    check(r == e, {"R2 value ", tag}, r, e);
    check(lhs == rhs, {"R2 congruence ", tag}, lhs, rhs);
    check(r < 2 * 256'(n), {"R2 below 2N ", tag}, r, 2 * 256'(n));
    check(lat == LAT, {"R3 latency ", tag}, 256'(lat), 256'(LAT));
    check(ok, {"R4 a_idx order ", tag}, 256'(ok), 256'(1));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] r0, r1;
    logic [127:0] n, a, b, b_keep;
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; start = 1'b0; ld_en = 1'b0; ld_mod = 1'b0; ld_addr = '0; ld_data = '0;
    rd_idx = '0; n_inv = '0; cur_a = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(!busy && !done, "R1 busy/done after reset", 256'({busy, done}), 256'(0));
    read_res(r0);
    check(r0 == '0, "R1 result zero after reset", r0, 256'(0));

    // directed corners
    n = {2'b00, rnd128()[125:0]}; n[0] = 1'b1;
    b = rnd128() % (2 * n);
    one_case("A zero", n, 128'd0, b, 1, 1, 0, b);
    one_case("A one B one", n, 128'd1, 128'd1, 0, 1, 0, 128'd1);
    one_case("max operands", n, 2 * n - 1, 2 * n - 1, 0, 1, 0, 2 * n - 1);
    one_case("tiny modulus", 128'd3, 128'd5, 128'd4, 1, 1, 0, 128'd4);
    n = {2'b00, {126{1'b1}}};
    one_case("wide modulus", n, 2 * n - 1, 2 * n - 2, 1, 1, 0, 2 * n - 2);

    // R8: out-of-range select reads zero
    for (int i = M + 1; i < 16; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      check(rd_word == '0, "R8 select above M", 256'(rd_word), 256'(0));
    end

    // random products, fresh N each time
    for (int k = 0; k < 10; k++) begin
      n = {2'b00, rnd128()[125:0]}; n[0] = 1'b1;
      a = rnd128() % (2 * n);
      b = rnd128() % (2 * n);
      one_case("random", n, a, b, 1, 1, 0, b);
    end

    // R5: keep N resident, reload only B
    b = rnd128() % (2 * n);
    a = rnd128() % (2 * n);
    one_case("R5 resident N", n, a, b, 0, 1, 0, b);

    // R6/R7: junk B write and second start during a running product
    b_keep = b;
    one_case("R6 R7 overlap", n, a, b_keep, 0, 0, 1, b_keep);
    one_case("R6 later product", n, a, b_keep, 0, 0, 0, b_keep);

    // R9: idle result held while loads happen
    read_res(r0);
    load_vec(1'b0, rnd128());
    repeat (5) @(negedge clk);
    read_res(r1);
    check(r1 == r0, "R9 result held while idle", r1, r0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule